// File: doc/BRIEF.md
# Flash Page Erase Controller

This block lets software wipe one 128-word page of program flash through a small byte-wide register bus. Software loads a 22-bit target address and selects the erase command. It then writes the two-byte key to the lock register and, as the very next access, sets the start bit. Address bits [21:8] pick the page and bits [7:0] play no part.

The controller rejects pages that are write-protected or outside the memory. Each rejection is reported through a sticky error bit. An accepted erase holds a CPU-stall output high while an internal timer counts down. When the count ends, every word of the page reads back as all ones, the start bit drops and the interrupt flag rises. A functional reset that cuts an erase short also leaves the error bit set. The error bit and the flash array belong to a power-on domain that only the power-on reset clears.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status register (offset 3) reads 0, the config register (offset 4) reads 0, and cpu_stall and irq are low.
- R2: An erase starts only when all of the following hold:
  - the config command field (offset 4, bits [2:0]) holds 3'b110;
  - the lock register (offset 5) has received 0x55 and then 0xAA;
  - the start bit (offset 3, bit 0) is written with 1 as the next bus access after those two lock writes.
- R3: No erase starts in any of these cases: the two lock values arrive in the wrong order, any other read or write comes between the lock writes and the start write, or the command field is not 3'b110. In each case cpu_stall stays low and the flash contents are unchanged.
- R4: cpu_stall is high for exactly ERASE_CYCLES cycles, starting in the cycle after the accepted start write. The start bit reads 1 during that time.
- R5: On completion, all 128 words of the selected page read all ones, whatever the value of address bits [7:0]. No other page changes.
- R6: On completion the start bit reads 0 and the interrupt flag (offset 3, bit 2) reads 1. The irq output equals the flag ANDed with the interrupt enable (offset 4, bit 7).
- R7: A start aimed at a protected page (page < PROT_PAGES) performs no erase, leaves cpu_stall low and the start bit 0, and sets the error bit (offset 3, bit 1).
- R8: A start aimed at a page at or above NUM_PAGES performs no erase and sets the error bit.
- R9: Writes to the address and config registers are ignored while an erase runs. The command field keeps its value through and after the erase.
- R10: A functional reset (rst_n low) during an erase leaves the error bit set afterwards and the page unerased. Writing 1 to bit 1 of the status register leaves the error bit set; writing 0 there clears it.
- R11: Writing 0 to bit 2 of the status register clears the interrupt flag and therefore irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the error bit and the array, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset: 0/1/2 address bytes, 3 status, 4 config, 5 lock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| erase_stb | output | 1 | One-cycle pulse that wipes the page in the array |
| cpu_stall | output | 1 | High while an erase runs |
| irq | output | 1 | Completion interrupt |
| mem_raddr | input | clog2(NUM_PAGES*PAGE_WORDS) | Flash word read address |
| mem_rdata | output | WORD_W | Flash word read data |

## Verification
The bench builds the block with NUM_PAGES=4, PROT_PAGES=1 and ERASE_CYCLES=12. With these values page 0 is protected, pages 1 to 3 can be erased, and page 4 as well as the top page number are invalid. The whole 512-word array can be compared after every trial. The short erase lets the bench also apply a reset in the middle of an erase and dozens of random unlock sequences, both intact and broken, each with an exact count of stall cycles.

// File: rtl/flash_erase_ctrl.sv
`timescale 1ns/1ps
module flash_erase_ctrl #(
  parameter int NUM_PAGES    = 4,
  parameter int PROT_PAGES   = 1,
  parameter int PAGE_WORDS   = 128,
  parameter int WORD_W       = 16,
  parameter int ERASE_CYCLES = 16
)(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    por_n,
  input  logic                                    bus_we,
  input  logic                                    bus_re,
  input  logic [2:0]                              bus_addr,
  input  logic [7:0]                              bus_wdata,
  output logic [7:0]                              bus_rdata,
  output logic                                    erase_stb,
  output logic                                    cpu_stall,
  output logic                                    irq,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0] mem_raddr,
  output logic [WORD_W-1:0]                       mem_rdata
);
  localparam int WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int WA_W  = $clog2(WORDS);
  localparam int CW    = $clog2(ERASE_CYCLES + 1);
  localparam logic [13:0] NP = 14'(NUM_PAGES);
  localparam logic [13:0] PP = 14'(PROT_PAGES);
  localparam logic [2:0] A_AL = 3'd0, A_AM = 3'd1, A_AH = 3'd2,
                         A_STAT = 3'd3, A_CFG = 3'd4, A_LOCK = 3'd5;
  localparam logic [2:0] CMD_ERASE = 3'b110;

  logic [21:0]   tgt;
  logic [2:0]    cmd;
  logic          ie, flag, busy, err, pend;
  logic [1:0]    ulk;
  logic [CW-1:0] tmr;
  logic [13:0]   page_r;
  logic [WORD_W-1:0] mem [WORDS];

  wire [13:0] page    = tgt[21:8];
  wire        page_ok = (page < NP) && !(page < PP);
  wire        go_wr   = bus_we && bus_addr == A_STAT && bus_wdata[0];
  wire        armed   = go_wr && ulk == 2'd2 && !busy && cmd == CMD_ERASE;
  wire        start   = armed && page_ok;
  wire        reject  = armed && !page_ok;
  wire        done    = busy && tmr == '0;
  wire        lk55    = bus_we && bus_addr == A_LOCK && bus_wdata == 8'h55;
  wire        lkaa    = bus_we && bus_addr == A_LOCK && bus_wdata == 8'hAA;

  assign erase_stb = done;
  assign cpu_stall = busy;
  assign irq       = flag & ie;
  assign mem_rdata = mem[mem_raddr];

  always_comb begin
    case (bus_addr)
      A_AL:    bus_rdata = tgt[7:0];
      A_AM:    bus_rdata = tgt[15:8];
      A_AH:    bus_rdata = {2'b00, tgt[21:16]};
      A_STAT:  bus_rdata = {5'b0, flag, err, busy};
      A_CFG:   bus_rdata = {ie, 4'b0, cmd};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt <= '0; cmd <= '0; ie <= 1'b0; flag <= 1'b0;
      busy <= 1'b0; ulk <= 2'd0; tmr <= '0; page_r <= '0;
    end else begin
      if (bus_we || bus_re) begin
        if (lk55)                   ulk <= 2'd1;
        else if (lkaa && ulk == 2'd1) ulk <= 2'd2;
        else                        ulk <= 2'd0;
      end
      if (bus_we && !busy) begin
        case (bus_addr)
          A_AL:  tgt[7:0]   <= bus_wdata;
          A_AM:  tgt[15:8]  <= bus_wdata;
          A_AH:  tgt[21:16] <= bus_wdata[5:0];
          A_CFG: begin cmd <= bus_wdata[2:0]; ie <= bus_wdata[7]; end
          default: ;
        endcase
      end
      if (bus_we && bus_addr == A_STAT && !bus_wdata[2]) flag <= 1'b0;
      if (start) begin
        busy <= 1'b1; tmr <= CW'(ERASE_CYCLES - 1); page_r <= page;
      end else if (busy) begin
        if (tmr == '0) begin busy <= 1'b0; flag <= 1'b1; end
        else tmr <= tmr - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      err <= 1'b0; pend <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (!rst_n) begin
      if (pend) begin err <= 1'b1; pend <= 1'b0; end
    end else begin
      if (start) pend <= 1'b1;
      if (done) begin
        pend <= 1'b0;
        for (int i = 0; i < PAGE_WORDS; i++)
          mem[WA_W'(int'(page_r) * PAGE_WORDS + i)] <= '1;
      end
      if (bus_we && bus_addr == A_STAT && !bus_wdata[1]) err <= 1'b0;
      if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_chk.sv
`timescale 1ns/1ps
module flash_erase_chk #(
  parameter int NUM_PAGES    = 4,
  parameter int PROT_PAGES   = 1,
  parameter int ERASE_CYCLES = 16
)(
  input logic        clk,
  input logic        rst_n,
  input logic        por_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        cpu_stall,
  input logic        flag,
  input logic [2:0]  cmd,
  input logic [21:0] tgt
);
  int stall_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stall_cnt <= 0;
    else        stall_cnt <= cpu_stall ? stall_cnt + 1 : 0;

  wire [13:0] pg = tgt[21:8];

  assert_start_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(cpu_stall) |-> $past(bus_we && bus_addr == 3'd3 && bus_wdata[0] && cmd == 3'b110));
  assert_stall_bound_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cpu_stall |-> stall_cnt < ERASE_CYCLES);
  assert_stall_length_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(cpu_stall) |-> $past(stall_cnt) == ERASE_CYCLES - 1);
  assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(flag) |-> $past(cpu_stall));
  assert_page_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cpu_stall |-> (int'(pg) >= PROT_PAGES && int'(pg) < NUM_PAGES));
  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cpu_stall && $past(cpu_stall)) |-> $stable(cmd));
endmodule

bind flash_erase_ctrl flash_erase_chk #(
  .NUM_PAGES(NUM_PAGES), .PROT_PAGES(PROT_PAGES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cpu_stall(cpu_stall), .flag(flag), .cmd(cmd), .tgt(tgt)
);

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctrl;
  localparam int NP = 4, PROT = 1, PW = 128, WW = 16, EC = 12;
  localparam int WORDS = NP * PW;
  localparam int AW = $clog2(WORDS);

  logic clk = 0, rst_n = 0, por_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic erase_stb, cpu_stall, irq;
  logic [AW-1:0] mem_raddr = 0;
  logic [WW-1:0] mem_rdata;

  flash_erase_ctrl #(.NUM_PAGES(NP), .PROT_PAGES(PROT), .PAGE_WORDS(PW),
    .WORD_W(WW), .ERASE_CYCLES(EC)) dut (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [WW-1:0] exp_mem [WORDS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_re = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic mem_check(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < WORDS; i++) begin
      mem_raddr = AW'(i); #0.01;
      if (mem_rdata !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  function automatic int pred(input int page, input int mode);
    if (mode != 0) return 0;
    if (page < PROT || page >= NP) return 2;
    return 1;
  endfunction

  task automatic set_target(input logic [13:0] page, input logic [7:0] offs, input logic [2:0] c, input bit en);
    wr(3'd0, offs); wr(3'd1, page[7:0]); wr(3'd2, {2'b0, page[13:8]});
    wr(3'd4, {en, 4'b0, c});
  endtask

  task automatic sequence_go(input int mode);
    logic [7:0] d;
    case (mode)
      1: begin wr(3'd5, 8'hAA); wr(3'd5, 8'h55); end
      2: begin wr(3'd5, 8'h55); rd(3'd3, d); wr(3'd5, 8'hAA); end
      3: begin wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd0, 8'h11); end
      4: begin wr(3'd5, 8'hAA); end
      default: begin wr(3'd5, 8'h55); wr(3'd5, 8'hAA); end
    endcase
    wr(3'd3, 8'h07);
  endtask

  task automatic trial(input logic [13:0] page, input logic [7:0] offs, input int mode, input bit en, input string tag);
    int expect_res, n;
    logic [7:0] d;
    expect_res = pred(int'(page), mode);
    set_target(page, offs, (mode == 5) ? 3'b000 : 3'b110, en);
    if (mode == 5) expect_res = 0;
    sequence_go(mode);
    n = 0;
    while (cpu_stall && n < 1000) begin n++; @(negedge clk); end
    chk(n == ((expect_res == 1) ? EC : 0), {tag, " R4 stall cycles"}, n, (expect_res == 1) ? EC : 0);
    rd(3'd3, d);
    chk(d[0] == 1'b0, {tag, " R6 go clear"}, d[0], 0);
    chk(d[1] == (expect_res == 2), {tag, " R7/R8 err"}, d[1], expect_res == 2);
    chk(d[2] == (expect_res == 1), {tag, " R6 flag"}, d[2], expect_res == 1);
    chk(irq == (en && expect_res == 1), {tag, " R6 irq"}, irq, en && expect_res == 1);
    if (expect_res == 1)
      for (int i = 0; i < PW; i++) exp_mem[int'(page) * PW + i] = '1;
    mem_check({tag, (expect_res == 1) ? " R5 page erased" : " R3 memory unchanged"});
    wr(3'd3, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);

    rd(3'd3, d); chk(d == 8'h00, "R1 status reset", d, 0);
    rd(3'd4, d); chk(d == 8'h00, "R1 config reset", d, 0);
    chk(!cpu_stall && !irq, "R1 stall/irq reset", {cpu_stall, irq}, 0);
    mem_check("R1 array zero");

    set_target(14'd2, 8'h40, 3'b110, 1'b1);
    sequence_go(0);
    rd(3'd3, d); chk(d[0] == 1'b1 && cpu_stall, "R4 go reads 1 while busy", d, 1);
    repeat (3) @(negedge clk);
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    chk(!cpu_stall, "R10 stall dropped by reset", cpu_stall, 0);
    rd(3'd3, d); chk(d == 8'h02, "R10 err after aborted erase", d, 8'h02);
    mem_check("R10 page not erased");
    wr(3'd3, 8'h02); rd(3'd3, d); chk(d[1], "R10 write 1 keeps err", d, 8'h02);
    wr(3'd3, 8'h00); rd(3'd3, d); chk(d == 8'h00, "R10 write 0 clears err", d, 0);

    set_target(14'd1, 8'hFF, 3'b110, 1'b1);
    sequence_go(0);
    @(negedge clk);
    wr(3'd4, 8'h00); wr(3'd1, 8'h03);
    n = 1;
    while (cpu_stall && n < 1000) begin n++; @(negedge clk); end
    rd(3'd4, d); chk(d == 8'h86, "R9 config kept through erase", d, 8'h86);
    rd(3'd1, d); chk(d == 8'h01, "R9 address write ignored while busy", d, 1);
    chk(irq, "R6 irq with enable", irq, 1);
    for (int i = 0; i < PW; i++) exp_mem[PW + i] = '1;
    mem_check("R5 offset ignored, page 1 erased");
    wr(3'd3, 8'h03); rd(3'd3, d);
    chk(d[2] == 1'b0 && !irq, "R11 flag cleared", d, 0);

    trial(14'd0, 8'h00, 0, 1'b0, "R7 protected page");
    trial(14'd4, 8'h00, 0, 1'b0, "R8 first invalid page");
    trial(14'h3FFF, 8'h00, 0, 1'b0, "R8 top page");
    trial(14'd3, 8'h00, 1, 1'b0, "R3 wrong order");
    trial(14'd3, 8'h00, 2, 1'b0, "R3 read between");
    trial(14'd3, 8'h00, 3, 1'b0, "R3 write before go");
    trial(14'd3, 8'h00, 4, 1'b0, "R3 only second key");
    trial(14'd3, 8'h00, 5, 1'b0, "R3 wrong command");
    trial(14'd3, 8'h22, 0, 1'b0, "R2 good erase no irq");

    for (int k = 0; k < 30; k++) begin
      int pg, md;
      pg = int'($urandom_range(0, 5));
      md = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 5));
      trial(14'(pg), 8'($urandom), md, 1'($urandom), "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule